// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave side of a serial link. Through it an external host reads and writes the chip's internal registers: a 24-bit conversion result (read only), a 24-bit control word, a 24-bit offset-correction word and a one-byte mode register. Each transfer opens with chip select going low. An 8-bit instruction byte follows, then one to three data bytes. Bits are sampled on rising serial-clock edges and launched on falling edges. All serial inputs are resynchronised into the block's own clock domain, so the serial clock has to be several times slower than the core clock.

The mode register controls how the link behaves at run time. One bit picks ascending or descending byte order for multi-byte registers. One bit picks most- or least-significant-bit-first on the wire, in both directions. One bit picks where read data leaves the chip: on the shared data pin, or on a separate output pin. A fourth bit puts the converter in standby. In standby the data-ready output is held inactive and a modulator-clock-disable output is raised. The data pin is bidirectional and is presented as an input, an output value and an output enable, for the pad ring to use. When a control-register write changes byte 2 or byte 1, the block raises a one-cycle restart request so the rest of the chip can recalibrate.

Top module: `ser_regport`

## Requirements
- R1: After reset the mode register reads 0x00 (descending byte order, MSB first, three-wire reads, not in standby). The control and offset registers read 0, `sdio_oe` is 0 and `recal` is 0.
- R2: The instruction byte is laid out as follows. Bit 7 is the direction: 1 for read, 0 for write. Bits 6:5 hold the byte count minus one, and a value of 3 is taken as three bytes. Bits 4:3 select the register: 0 conversion data, 1 control, 2 offset, 3 mode. Bit 2 is ignored. Bits 1:0 hold the first byte index, and a value of 3 is taken as 2. Exactly that many data bytes follow, and a write stores each one at its current byte index.
- R3: When mode bit 2 is 0, read data leaves on `sdio_out`, and `sdio_oe` is 1 for the whole data phase of a read.
- R4: When mode bit 2 is 1, read data leaves on `sdo` and `sdio_oe` stays 0. Writes still arrive on `sdio_in`.
- R5: When mode bit 1 is 1, every byte travels least significant bit first, instruction bytes included and in both directions. When it is 0, every byte travels most significant bit first.
- R6: When mode bit 0 is 0, the byte index steps down after each data byte, and wraps from 0 to 2.
- R7: When mode bit 0 is 1, the byte index steps up after each data byte, and wraps from 2 to 0.
- R8: When a write to the control register finishes and any of its bytes went to index 2 or 1, `recal` is high for exactly one clock cycle. A write that touched only index 0 leaves `recal` low.
- R9: When mode bit 3 is 1, `drdy_n` and `mod_clk_off` are both 1. When mode bit 3 is 0, `drdy_n` follows `conv_drdy_n` and `mod_clk_off` is 0.
- R10: Raising `cs_n` abandons any partly shifted byte, and the next transfer starts again with an instruction byte.
- R11: A read of the conversion-data register returns the value `conv_data` held when its instruction byte completed, even if `conv_data` changes during the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| cs_n | input | 1 | Chip select, active low |
| sdio_in | input | 1 | Value seen on the bidirectional data pin |
| sdio_out | output | 1 | Value driven onto the bidirectional data pin |
| sdio_oe | output | 1 | Output enable for the bidirectional data pin |
| sdo | output | 1 | Dedicated read-data output (four-wire mode) |
| conv_data | input | 24 | Latest conversion result |
| conv_drdy_n | input | 1 | Data-ready from the conversion path, active low |
| drdy_n | output | 1 | Data-ready to the host, active low |
| mod_clk_off | output | 1 | Modulator clock disable |
| recal | output | 1 | One-cycle restart/recalibrate request |
| ctrl_q | output | 24 | Control register contents |
| offs_q | output | 24 | Offset register contents |

## Verification
If the byte-index or bit-counter state goes wrong, the effect is visible within the same transfer. Bytes come back in the wrong order, or a write lands in the wrong lane of `ctrl_q`/`offs_q`, and a readback in the opposite order exposes it. If the mode register is corrupted, the very next byte on the link shows it: the bit order is mirrored, data appears on the wrong pin, or `sdio_oe` rises when it should not. A phase register that fails to clear when `cs_n` rises shows up as a garbled first byte in the following transfer. A bad touched-byte flag shows up as a missing or extra `recal` pulse a few core cycles after the last write byte.

// File: rtl/ser_regport_pkg.sv
package ser_regport_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_OFFS = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  // Mode register layout, bit 3 down to bit 0
  typedef struct packed {
    logic standby;
    logic four_wire;
    logic lsb_first;
    logic byte_asc;
  } mode_t;

endpackage

// File: rtl/ser_regport_sync.sv
module ser_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic din_s
);

  logic [STAGES:0]   sclk_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '1;
      cs_q   <= '1;
      din_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[STAGES-1:0], sclk};
      cs_q   <= {cs_q[STAGES-2:0], cs_n};
      din_q  <= {din_q[STAGES-2:0], din};
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_q[STAGES];
  assign cs_act    = ~cs_q[STAGES-1];
  assign din_s     = din_q[STAGES-1];

endmodule

// File: rtl/ser_regport_regs.sv
module ser_regport_regs
  import ser_regport_pkg::*;
#(
  parameter int DW = 24,
  localparam int NB = DW / 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  reg_sel_e       wr_sel,
  input  logic [IW-1:0]  wr_idx,
  input  logic [7:0]     wr_byte,
  input  logic           snap_en,
  input  reg_sel_e       rd_sel,
  input  logic [IW-1:0]  rd_idx,
  input  logic [DW-1:0]  conv_data,
  output logic [7:0]     rd_byte,
  output mode_t          mode,
  output logic [DW-1:0]  ctrl_q,
  output logic [DW-1:0]  offs_q
);

  logic [NB-1:0][7:0] ctrl_r, ctrl_n;
  logic [NB-1:0][7:0] offs_r, offs_n;
  logic [NB-1:0][7:0] snap_r, snap_n;
  logic [NB-1:0][7:0] conv_b;
  mode_t              mode_r, mode_n;

  assign conv_b = conv_data;

  always_comb begin
    ctrl_n = ctrl_r;
    offs_n = offs_r;
    mode_n = mode_r;
    snap_n = snap_en ? conv_b : snap_r;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_CTRL: ctrl_n[wr_idx] = wr_byte;
        SEL_OFFS: offs_n[wr_idx] = wr_byte;
        SEL_MODE: mode_n         = mode_t'(wr_byte[3:0]);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      offs_r <= '0;
      snap_r <= '0;
      mode_r <= '0;
    end else begin
      ctrl_r <= ctrl_n;
      offs_r <= offs_n;
      snap_r <= snap_n;
      mode_r <= mode_n;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_DATA: rd_byte = snap_en ? conv_b[rd_idx] : snap_r[rd_idx];
      SEL_CTRL: rd_byte = ctrl_r[rd_idx];
      SEL_OFFS: rd_byte = offs_r[rd_idx];
      default:  rd_byte = {4'b0000, mode_r};
    endcase
  end

  assign mode   = mode_r;
  assign ctrl_q = ctrl_r;
  assign offs_q = offs_r;

endmodule

// File: rtl/ser_regport_seq.sv
module ser_regport_seq
  import ser_regport_pkg::*;
#(
  parameter int NB = 3,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int LW = $clog2(NB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rise,
  input  logic           fall,
  input  logic           cs_act,
  input  logic           din,
  input  mode_t          mode,
  input  logic [7:0]     rd_byte,
  output reg_sel_e       rd_sel,
  output logic [IW-1:0]  rd_idx,
  output logic           wr_en,
  output reg_sel_e       wr_sel,
  output logic [IW-1:0]  wr_idx,
  output logic [7:0]     wr_byte,
  output logic           snap_en,
  output logic           out_bit,
  output logic           rd_active,
  output logic           recal
);

  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  phase_e        phase_q, phase_n;
  logic [2:0]    bitcnt_q, bitcnt_n;
  logic [7:0]    rx_q, rx_n, rx_nx;
  logic [7:0]    tx_q, tx_n;
  logic          is_read_q, is_read_n;
  reg_sel_e      sel_q, sel_n;
  logic [IW-1:0] idx_q, idx_n, idx_step, start_dec;
  logic [LW-1:0] left_q, left_n, left_dec;
  logic          touched_q, touched_n;
  logic          out_q, out_n;
  logic          recal_q, recal_n;
  logic          byte_done;

  assign rx_nx     = mode.lsb_first ? {din, rx_q[7:1]} : {rx_q[6:0], din};
  assign byte_done = rise && (bitcnt_q == 3'd7);
  assign left_dec  = (int'(rx_nx[6:5]) + 1 > NB) ? LW'(NB) : LW'(int'(rx_nx[6:5]) + 1);
  assign start_dec = (int'(rx_nx[1:0]) > NB - 1) ? LAST : IW'(rx_nx[1:0]);
  assign idx_step  = mode.byte_asc ? ((idx_q == LAST) ? '0 : IW'(idx_q + 1'b1))
                                   : ((idx_q == '0) ? LAST : IW'(idx_q - 1'b1));

  always_comb begin
    phase_n   = phase_q;
    bitcnt_n  = bitcnt_q;
    rx_n      = rx_q;
    tx_n      = tx_q;
    is_read_n = is_read_q;
    sel_n     = sel_q;
    idx_n     = idx_q;
    left_n    = left_q;
    touched_n = touched_q;
    out_n     = out_q;
    recal_n   = 1'b0;
    wr_en     = 1'b0;
    snap_en   = 1'b0;
    rd_sel    = sel_q;
    rd_idx    = idx_step;
    if (!cs_act) begin
      phase_n   = PH_INSTR;
      bitcnt_n  = '0;
      out_n     = 1'b0;
      touched_n = 1'b0;
    end else begin
      if (rise) begin
        rx_n     = rx_nx;
        bitcnt_n = 3'(bitcnt_q + 3'd1);
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_INSTR: begin
            is_read_n = rx_nx[7];
            sel_n     = reg_sel_e'(rx_nx[4:3]);
            idx_n     = start_dec;
            left_n    = left_dec;
            touched_n = 1'b0;
            phase_n   = PH_DATA;
            rd_sel    = reg_sel_e'(rx_nx[4:3]);
            rd_idx    = start_dec;
            snap_en   = rx_nx[7] && (reg_sel_e'(rx_nx[4:3]) == SEL_DATA);
            tx_n      = rd_byte;
          end
          PH_DATA: begin
            if (!is_read_q) begin
              wr_en = 1'b1;
              if (sel_q == SEL_CTRL && idx_q != '0) touched_n = 1'b1;
              if (left_q == LW'(1) && sel_q == SEL_CTRL && (touched_q || idx_q != '0))
                recal_n = 1'b1;
            end
            left_n = LW'(left_q - 1'b1);
            idx_n  = idx_step;
            tx_n   = rd_byte;
            if (left_q == LW'(1)) phase_n = PH_DONE;
          end
          default: ;
        endcase
      end
      if (fall) begin
        if (phase_q == PH_DATA && is_read_q)
          out_n = mode.lsb_first ? tx_q[bitcnt_q] : tx_q[~bitcnt_q];
        else
          out_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_INSTR;
      bitcnt_q  <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      is_read_q <= 1'b0;
      sel_q     <= SEL_DATA;
      idx_q     <= '0;
      left_q    <= '0;
      touched_q <= 1'b0;
      out_q     <= 1'b0;
      recal_q   <= 1'b0;
    end else begin
      phase_q   <= phase_n;
      bitcnt_q  <= bitcnt_n;
      rx_q      <= rx_n;
      tx_q      <= tx_n;
      is_read_q <= is_read_n;
      sel_q     <= sel_n;
      idx_q     <= idx_n;
      left_q    <= left_n;
      touched_q <= touched_n;
      out_q     <= out_n;
      recal_q   <= recal_n;
    end
  end

  assign wr_sel    = sel_q;
  assign wr_idx    = idx_q;
  assign wr_byte   = rx_nx;
  assign out_bit   = out_q;
  assign rd_active = (phase_q == PH_DATA) && is_read_q;
  assign recal     = recal_q;

endmodule

// File: rtl/ser_regport.sv
module ser_regport
  import ser_regport_pkg::*;
#(
  parameter int DW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdio_in,
  output logic          sdio_out,
  output logic          sdio_oe,
  output logic          sdo,
  input  logic [DW-1:0] conv_data,
  input  logic          conv_drdy_n,
  output logic          drdy_n,
  output logic          mod_clk_off,
  output logic          recal,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] offs_q
);

  localparam int NB = DW / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [1:0]    rst_q;
  logic          rst_s;
  logic          rise, fall, cs_act, din_s;
  logic          wr_en, snap_en, out_bit, rd_active;
  reg_sel_e      wr_sel, rd_sel;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_byte, rd_byte;
  mode_t         mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  ser_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .sclk(sclk), .cs_n(cs_n), .din(sdio_in),
    .sclk_rise(rise), .sclk_fall(fall), .cs_act(cs_act), .din_s(din_s)
  );

  ser_regport_seq #(.NB(NB)) u_seq (
    .clk(clk), .rst_n(rst_s), .rise(rise), .fall(fall), .cs_act(cs_act),
    .din(din_s), .mode(mode_q), .rd_byte(rd_byte), .rd_sel(rd_sel),
    .rd_idx(rd_idx), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .snap_en(snap_en), .out_bit(out_bit),
    .rd_active(rd_active), .recal(recal)
  );

  ser_regport_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_byte(wr_byte), .snap_en(snap_en),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .conv_data(conv_data),
    .rd_byte(rd_byte), .mode(mode_q), .ctrl_q(ctrl_q), .offs_q(offs_q)
  );

  assign sdio_out    = out_bit;
  assign sdio_oe     = rd_active && cs_act && !mode_q.four_wire;
  assign sdo         = (rd_active && mode_q.four_wire) ? out_bit : 1'b0;
  assign drdy_n      = mode_q.standby | conv_drdy_n;
  assign mod_clk_off = mode_q.standby;

endmodule

// File: rtl/ser_regport_chk.sv
module ser_regport_chk
  import ser_regport_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sdio_oe,
  input logic       recal,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [3:0] mode,
  input logic       drdy_n,
  input logic       mod_clk_off
);

  // R4: four-wire mode never turns the shared pin around
  assert_no_oe_four_wire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode[2] |-> !sdio_oe);

  // R8: the restart request lasts one cycle
  assert_recal_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recal |=> !recal);

  // R8: the restart request follows a control-register write
  assert_recal_after_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recal |-> $past(wr_en && wr_sel == SEL_CTRL));

  // R2: mode bits move only on a mode-register write
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_MODE) |=> $stable(mode));

  // R9: standby forces data-ready inactive and stops the modulator clock
  assert_standby_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode[3] |-> (drdy_n && mod_clk_off));

endmodule

bind ser_regport ser_regport_chk u_chk (
  .clk(clk), .rst_n(rst_s), .sdio_oe(sdio_oe), .recal(recal),
  .wr_en(wr_en), .wr_sel(wr_sel), .mode(mode_q),
  .drdy_n(drdy_n), .mod_clk_off(mod_clk_off)
);

// File: tb/sim_ser_regport.sv
`timescale 1ns/1ps
module sim_ser_regport;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, cs_n, sdio_in;
  logic        sdio_out, sdio_oe, sdo;
  logic [23:0] conv_data;
  logic        conv_drdy_n;
  logic        drdy_n, mod_clk_off, recal;
  logic [23:0] ctrl_q, offs_q;

  int n_tests = 0;
  int n_fail  = 0;
  int recal_cnt = 0;
  bit done = 1'b0;

  logic [2:0][7:0] m_ctrl, m_offs;
  logic [7:0]      m_mode;
  logic [7:0]      got_b;
  logic            oe_any, oe_all;
  logic [2:0][7:0] rd_bytes;
  logic            rd_oe_any, rd_oe_all;

  always #2.5 clk = ~clk;

  ser_regport u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .conv_data(conv_data),
    .conv_drdy_n(conv_drdy_n), .drdy_n(drdy_n), .mod_clk_off(mod_clk_off),
    .recal(recal), .ctrl_q(ctrl_q), .offs_q(offs_q)
  );

  always @(posedge clk) if (rst_n && recal) recal_cnt <= recal_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] step(input logic [1:0] i, input logic asc);
    if (asc) return (i == 2'd2) ? 2'd0 : i + 2'd1;
    return (i == 2'd0) ? 2'd2 : i - 2'd1;
  endfunction

  function automatic logic [7:0] mk(input logic rd, input int cnt, input logic [1:0] sel, input logic [1:0] st);
    logic [1:0] c = 2'(cnt - 1);
    return {rd, c, sel, 1'b0, st};
  endfunction

  task automatic xbyte(input logic [7:0] b, input logic use_sdo);
    got_b = '0; oe_any = 1'b0; oe_all = 1'b1;
    for (int k = 0; k < 8; k++) begin
      int pos;
      pos = m_mode[1] ? k : 7 - k;
      sclk = 1'b0; sdio_in = b[pos];
      half();
      got_b[pos] = use_sdo ? sdo : sdio_out;
      oe_any |= sdio_oe; oe_all &= sdio_oe;
      sclk = 1'b1;
      half();
    end
  endtask

  task automatic cs_open();
    cs_n = 1'b0; half(); half();
  endtask

  task automatic cs_close();
    half(); cs_n = 1'b1; half(); half();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] st, input int cnt, input logic [2:0][7:0] b);
    logic [1:0] idx = st;
    logic       asc = m_mode[0];
    cs_open();
    xbyte(mk(1'b0, cnt, sel, st), 1'b0);
    for (int i = 0; i < cnt; i++) begin
      xbyte(b[i], 1'b0);
      if (sel == 2'd1) m_ctrl[idx] = b[i];
      if (sel == 2'd2) m_offs[idx] = b[i];
      if (sel == 2'd3) m_mode = {4'h0, b[i][3:0]};
      idx = step(idx, asc);
    end
    cs_close();
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] st, input int cnt, input logic use_sdo);
    rd_bytes = '0; rd_oe_any = 1'b0; rd_oe_all = 1'b1;
    cs_open();
    xbyte(mk(1'b1, cnt, sel, st), use_sdo);
    rd_oe_any |= oe_any;
    for (int i = 0; i < cnt; i++) begin
      xbyte(8'h00, use_sdo);
      rd_bytes[i] = got_b;
      rd_oe_any |= oe_any; rd_oe_all &= oe_all;
    end
    cs_close();
  endtask

  task automatic exp_read(input string req, input logic [2:0][7:0] src, input logic [1:0] st, input int cnt);
    logic [1:0] idx = st;
    for (int i = 0; i < cnt; i++) begin
      chk(rd_bytes[i] == src[idx], req, {24'h0, rd_bytes[i]}, {24'h0, src[idx]});
      idx = step(idx, m_mode[0]);
    end
  endtask

  task automatic t_reset();
    chk(sdio_oe == 1'b0 && recal == 1'b0, "R1 oe/recal idle", {30'h0, sdio_oe, recal}, 32'h0);
    chk(ctrl_q == 24'h0 && offs_q == 24'h0, "R1 ctrl/offset reset", {8'h0, ctrl_q ^ offs_q}, 32'h0);
    chk(mod_clk_off == 1'b0 && drdy_n == 1'b0, "R1 R9 standby off", {30'h0, mod_clk_off, drdy_n}, 32'h0);
    rd(2'd3, 2'd0, 1, 1'b0);
    chk(rd_bytes[0] == 8'h00, "R1 mode reads zero", {24'h0, rd_bytes[0]}, 32'h0);
  endtask

  task automatic t_desc_three_wire();
    wr(2'd2, 2'd2, 3, {8'hC3, 8'hB2, 8'hA1});
    chk(offs_q == 24'hA1B2C3, "R2 R6 offset descending write", {8'h0, offs_q}, 32'hA1B2C3);
    rd(2'd2, 2'd2, 3, 1'b0);
    exp_read("R3 R6 descending read", m_offs, 2'd2, 3);
    chk(rd_oe_all == 1'b1, "R3 oe during read data", {31'h0, rd_oe_all}, 32'h1);
    rd(2'd2, 2'd0, 2, 1'b0);
    exp_read("R6 wrap 0 to 2", m_offs, 2'd0, 2);
  endtask

  task automatic t_asc_recal();
    int c0;
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h01});
    c0 = recal_cnt;
    wr(2'd1, 2'd0, 3, {8'h33, 8'h22, 8'h11});
    chk(ctrl_q == 24'h332211, "R7 ctrl ascending write", {8'h0, ctrl_q}, 32'h332211);
    chk(recal_cnt - c0 == 1, "R8 one recal pulse", recal_cnt - c0, 32'd1);
    rd(2'd1, 2'd2, 2, 1'b0);
    exp_read("R7 wrap 2 to 0", m_ctrl, 2'd2, 2);
    c0 = recal_cnt;
    wr(2'd1, 2'd0, 1, {8'h0, 8'h0, 8'h44});
    chk(recal_cnt == c0, "R8 byte0-only write no recal", recal_cnt - c0, 32'd0);
    chk(ctrl_q == 24'h332244, "R8 byte0 stored", {8'h0, ctrl_q}, 32'h332244);
    wr(2'd1, 2'd1, 1, {8'h0, 8'h0, 8'h55});
    chk(recal_cnt - c0 == 1, "R8 byte1 write recal", recal_cnt - c0, 32'd1);
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h00});
  endtask

  task automatic t_lsb();
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h02});
    rd(2'd2, 2'd2, 3, 1'b0);
    exp_read("R5 lsb-first read", m_offs, 2'd2, 3);
    wr(2'd2, 2'd0, 1, {8'h0, 8'h0, 8'h8E});
    chk(offs_q[7:0] == 8'h8E, "R5 lsb-first write", {24'h0, offs_q[7:0]}, 32'h8E);
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h00});
    rd(2'd3, 2'd0, 1, 1'b0);
    chk(rd_bytes[0] == 8'h00, "R5 back to msb-first", {24'h0, rd_bytes[0]}, 32'h0);
  endtask

  task automatic t_four_wire();
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h04});
    rd(2'd2, 2'd2, 3, 1'b1);
    exp_read("R4 data on sdo", m_offs, 2'd2, 3);
    chk(rd_oe_any == 1'b0, "R4 sdio not driven", {31'h0, rd_oe_any}, 32'h0);
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h00});
  endtask

  task automatic t_standby();
    conv_drdy_n = 1'b0; half();
    chk(drdy_n == 1'b0, "R9 drdy follows input", {31'h0, drdy_n}, 32'h0);
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h08});
    chk(drdy_n == 1'b1 && mod_clk_off == 1'b1, "R9 standby outputs", {30'h0, drdy_n, mod_clk_off}, 32'h3);
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h00});
    chk(drdy_n == 1'b0 && mod_clk_off == 1'b0, "R9 standby cleared", {30'h0, drdy_n, mod_clk_off}, 32'h0);
  endtask

  task automatic t_abort();
    cs_open();
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b0; sdio_in = 1'b1; half();
      sclk = 1'b1; half();
    end
    cs_close();
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h01});
    rd(2'd3, 2'd0, 1, 1'b0);
    chk(rd_bytes[0] == 8'h01, "R10 resync after abort", {24'h0, rd_bytes[0]}, 32'h01);
    wr(2'd3, 2'd0, 1, {8'h0, 8'h0, 8'h00});
  endtask

  task automatic t_snapshot();
    conv_data = 24'h5A6B7C;
    cs_open();
    xbyte(mk(1'b1, 3, 2'd0, 2'd2), 1'b0);
    conv_data = 24'h123456;
    for (int i = 0; i < 3; i++) begin
      xbyte(8'h00, 1'b0);
      rd_bytes[i] = got_b;
    end
    cs_close();
    chk(rd_bytes[0] == 8'h5A && rd_bytes[1] == 8'h6B && rd_bytes[2] == 8'h7C,
        "R11 snapshot held", {8'h0, rd_bytes[0], rd_bytes[1], rd_bytes[2]}, 32'h5A6B7C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; sdio_in = 1'b0;
    conv_data = 24'h0; conv_drdy_n = 1'b0;
    m_ctrl = '0; m_offs = '0; m_mode = '0;
    repeat (5) @(posedge clk); #1;
    rst_n = 1'b1;
    half();
    t_reset();
    t_desc_three_wire();
    t_asc_recal();
    t_lsb();
    t_four_wire();
    t_standby();
    t_abort();
    t_snapshot();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule